// File: doc/BRIEF.md
# I2C Register Slave with Pointer Auto-Increment

This block sits on a two-wire serial bus as a target device with a fixed 7-bit address and gives an external master access to a 128-entry, 8-bit register space. The register space lives outside the block. The block reaches it through a simple port: a one-cycle write strobe with address and data, and a one-cycle read strobe whose data must be returned on the following clock. Both bus lines are oversampled by the system clock. The block sees each line as a plain input and drives SDA only through a pull-low enable, as an open-drain pad would.

A transfer opens with a start condition and an address byte. If the address matches and the direction bit is 0, the next byte is a sub-address. Its low seven bits load a register pointer, and its top bit chooses whether that pointer steps after each data byte. Further bytes are written through the pointer. To read, the master first sets the pointer with a write-form transfer, then issues a repeated start with the read-form address. The block then returns bytes from the pointer for as long as the master acknowledges them.

A separate select input parks the block when the pins are shared with another serial protocol.

Top module: `i2c_regslave`

## Requirements
- R1: After reset `sda_pull`, `reg_wr_en` and `reg_rd_en` are all 0.
- R2: An address byte of 0xBE (address 1011111, direction bit 0) is acknowledged: SDA is held low while SCL is high on the ninth clock.
- R3: An address byte whose upper seven bits differ from 1011111 gets no acknowledge. The block then causes no register access and does not drive SDA until the next start condition.
- R4: The byte after an acknowledged 0xBE is a sub-address and is acknowledged. Bits 6:0 load the register pointer, and bit 7 set to 1 enables auto-increment.
- R5: Each further byte written is acknowledged and stored through a single one-cycle `reg_wr_en` pulse that carries the pointer on `reg_addr` and the byte on `reg_wdata`.
- R6: With auto-increment on, the pointer steps by one modulo 128 after every data byte, whether written or read. With it off, every byte of the transfer uses the same register.
- R7: After a repeated start and the read-form address 0xBF is acknowledged, the block raises `reg_rd_en` for the pointer, samples `reg_rdata` on the cycle after the strobe, and sends that byte MSB first.
- R8: A master acknowledge (SDA low on the ninth clock) makes the block send the next byte. A master not-acknowledge ends the read: no further read strobe follows and SDA stays released.
- R9: The block never pulls SDA during the master's acknowledge bit, and it changes its SDA drive only while SCL is low.
- R10: While `bus_sel` is low the block ignores the bus. It acknowledges nothing, makes no register access and keeps SDA released.
- R11: A start is SDA falling with SCL high, and a stop is SDA rising with SCL high. A stop in the middle of a byte drops that byte without a register write.
- R12: A pulse on SDA shorter than three system clocks is filtered out. It neither creates a false start or stop nor corrupts the byte in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | 1 enables the two-wire target; 0 parks it |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low through the open-drain pad |
| reg_addr | output | 7 | Register address for the current access |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Byte to write |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data, valid the cycle after `reg_rd_en` |

## Verification
A wrong pointer or auto-increment flag cannot be seen until a later byte lands at the wrong register. The bench therefore reads back the whole register space in one auto-incrementing burst, so any stray or misplaced write shows up as a miscompare within that single transfer. A broken phase or bit counter shows up within one byte time as a missing or misplaced acknowledge on the ninth clock. An edge-detection or filter fault shows up as a spurious start or stop that loses the byte in flight, or as SDA drive moving while SCL is high, which a bench monitor counts.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Protocol phase of the target engine
  typedef enum logic [2:0] {
    PH_IDLE,   // not addressed, waiting for a start
    PH_ADDR,   // shifting in the address byte
    PH_SUB,    // shifting in the sub-address byte
    PH_WDATA,  // shifting in a write data byte
    PH_ACK,    // driving our acknowledge bit
    PH_TX,     // shifting out a read data byte
    PH_MACK    // master acknowledge bit of a read byte
  } phase_t;

endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int   SYNC_STAGES = 2,
  parameter int   FILT_LEN    = 3,
  parameter logic RESET_VAL   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic clean_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic                   clean_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q  <= {SYNC_STAGES{RESET_VAL}};
      hist_q  <= {FILT_LEN{RESET_VAL}};
      clean_q <= RESET_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      // the output moves only when the whole history window agrees
      if (&hist_q)
        clean_q <= 1'b1;
      else if (~|hist_q)
        clean_q <= 1'b0;
    end
  end

  assign clean_o = clean_q;

endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  // data edges while the clock is steadily high are bus conditions
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

  AST_COND_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({scl_rise, scl_fall, start_c, stop_c})); // R11

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h5F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  input  logic          sda_f,
  output logic          sda_pull,
  output logic [DW-2:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rdata
);

  localparam int AW = DW - 1;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);

  phase_t          phase_q, after_q;
  logic [CW-1:0]   cnt_q;
  logic [DW-1:0]   rx_q, tx_q, wdata_q;
  logic [AW-1:0]   ptr_q, addr_q, nptr;
  logic            ai_q, rd_q, mack_q, pull_q, wr_q, rd_en_q;

  assign nptr = ai_q ? ptr_q + 1'b1 : ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      after_q <= PH_IDLE;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      wdata_q <= '0;
      ptr_q   <= '0;
      addr_q  <= '0;
      ai_q    <= 1'b0;
      rd_q    <= 1'b0;
      mack_q  <= 1'b0;
      pull_q  <= 1'b0;
      wr_q    <= 1'b0;
      rd_en_q <= 1'b0;
    end else begin
      wr_q    <= 1'b0;
      rd_en_q <= 1'b0;
      rd_q    <= rd_en_q;
      if (rd_q)
        tx_q <= reg_rdata;

      if (!enable) begin
        phase_q <= PH_IDLE;
        pull_q  <= 1'b0;
      end else if (start_c) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
        pull_q  <= 1'b0;
      end else if (stop_c) begin
        phase_q <= PH_IDLE;
        pull_q  <= 1'b0;
      end else begin
        case (phase_q)
          PH_ADDR, PH_SUB, PH_WDATA: begin
            if (scl_rise && cnt_q != CNT_FULL) begin
              rx_q  <= {rx_q[DW-2:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_FULL) begin
              cnt_q <= '0;
              if (phase_q == PH_ADDR) begin
                if (rx_q[DW-1:1] == DEV_ADDR) begin
                  pull_q  <= 1'b1;
                  phase_q <= PH_ACK;
                  if (rx_q[0]) begin
                    after_q <= PH_TX;
                    rd_en_q <= 1'b1;
                    addr_q  <= ptr_q;
                  end else begin
                    after_q <= PH_SUB;
                  end
                end else begin
                  phase_q <= PH_IDLE;
                end
              end else if (phase_q == PH_SUB) begin
                ptr_q   <= rx_q[AW-1:0];
                ai_q    <= rx_q[DW-1];
                pull_q  <= 1'b1;
                phase_q <= PH_ACK;
                after_q <= PH_WDATA;
              end else begin
                wr_q    <= 1'b1;
                addr_q  <= ptr_q;
                wdata_q <= rx_q;
                ptr_q   <= nptr;
                pull_q  <= 1'b1;
                phase_q <= PH_ACK;
                after_q <= PH_WDATA;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              phase_q <= after_q;
              if (after_q == PH_TX) begin
                pull_q <= ~tx_q[DW-1];
                tx_q   <= {tx_q[DW-2:0], 1'b0};
                cnt_q  <= CW'(1);
              end else begin
                pull_q <= 1'b0;
                cnt_q  <= '0;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (cnt_q == CNT_FULL) begin
                pull_q  <= 1'b0;
                phase_q <= PH_MACK;
              end else begin
                pull_q <= ~tx_q[DW-1];
                tx_q   <= {tx_q[DW-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          PH_MACK: begin
            if (scl_rise) begin
              ptr_q  <= nptr;
              mack_q <= ~sda_f;
              if (!sda_f) begin
                rd_en_q <= 1'b1;
                addr_q  <= nptr;
              end
            end else if (scl_fall) begin
              if (mack_q) begin
                pull_q  <= ~tx_q[DW-1];
                tx_q    <= {tx_q[DW-2:0], 1'b0};
                cnt_q   <= CW'(1);
                phase_q <= PH_TX;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull  = pull_q;
  assign reg_addr  = addr_q;
  assign reg_wr_en = wr_q;
  assign reg_wdata = wdata_q;
  assign reg_rd_en = rd_en_q;

  AST_WR_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |-> sda_pull); // R5
  AST_ACCESS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr_en && reg_rd_en)); // R7
  AST_QUIET_PARKED: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!sda_pull && !reg_wr_en && !reg_rd_en)); // R10
  AST_MACK_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_MACK) |-> !sda_pull); // R9

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter int DW          = 8,
  parameter logic [DW-2:0] DEV_ADDR = 7'h5F,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  output logic [DW-2:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wdata,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rdata
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_vec, clean_vec;
  logic scl_f, sda_f, scl_rise, scl_fall, start_c, stop_c;

  assign raw_vec = {sda_i, scl_i};

  for (genvar gi = 0; gi < NLINES; gi++) begin : g_line
    i2cs_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN),
      .RESET_VAL  (1'b1)
    ) u_filt (
      .clk    (clk),
      .rst    (rst),
      .raw_i  (raw_vec[gi]),
      .clean_o(clean_vec[gi])
    );
  end

  assign scl_f = clean_vec[0];
  assign sda_f = clean_vec[1];

  i2cs_cond u_cond (
    .clk     (clk),
    .rst     (rst),
    .scl_f   (scl_f),
    .sda_f   (sda_f),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .start_c (start_c),
    .stop_c  (stop_c)
  );

  i2cs_engine #(
    .DW      (DW),
    .DEV_ADDR(DEV_ADDR)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .enable   (bus_sel),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_c  (start_c),
    .stop_c   (stop_c),
    .sda_f    (sda_f),
    .sda_pull (sda_pull),
    .reg_addr (reg_addr),
    .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata)
  );

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst || !bus_sel)
    ($past(bus_sel) && !$stable(sda_pull)) |-> !$past(scl_f)); // R9

endmodule

// File: tb/i2c_regslave_bench.sv
module i2c_regslave_bench;

  localparam int Q = 8;
  localparam int WATCHDOG = 195000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b1;
  logic       m_scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_pull;
  logic [6:0] reg_addr;
  logic       reg_wr_en, reg_rd_en;
  logic [7:0] reg_wdata, reg_rdata;
  logic       sda_line;

  int n_chk = 0, n_bad = 0;
  int wr_cnt = 0, rd_cnt = 0, r9_bad = 0;
  bit done = 1'b0;

  logic [7:0] mem [128];
  logic [7:0] expv [128];
  logic [7:0] wbuf [16];
  logic       pull_d = 1'b0;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_pull;

  i2c_regslave u_i2c_regslave (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .scl_i    (m_scl),
    .sda_i    (sda_line),
    .sda_pull (sda_pull),
    .reg_addr (reg_addr),
    .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata),
    .reg_rd_en(reg_rd_en),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 3) ^ 8'h5A);
  endfunction

  // register space model with synchronous read
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
      reg_rdata <= '0;
    end else begin
      if (reg_wr_en) mem[reg_addr] <= reg_wdata;
      if (reg_rd_en) reg_rdata <= mem[reg_addr];
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (reg_wr_en) wr_cnt <= wr_cnt + 1;
      if (reg_rd_en) rd_cnt <= rd_cnt + 1;
      pull_d <= sda_pull;
      if (sda_pull != pull_d && m_scl) r9_bad <= r9_bad + 1; // R9 monitor
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_i);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_i);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wt(Q);
    m_scl = 1'b1; wt(Q);
    m_sda = 1'b1; wt(2 * Q);
  endtask

  task automatic bit_io(input logic b, input bit glitch, output logic seen, output logic pseen);
    m_sda = b; wt(Q);
    m_scl = 1'b1; wt(Q / 2);
    if (glitch) begin
      m_sda = 1'b0; wt(1);
      m_sda = b;
    end
    wt(Q / 2);
    seen = sda_line; pseen = sda_pull;
    wt(Q);
    m_scl = 1'b0; wt(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input int gbit, output logic ack);
    logic s, p;
    for (int i = 7; i >= 0; i--) bit_io(b[i], (i == gbit), s, p);
    bit_io(1'b1, 1'b0, s, p);
    ack = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s, p;
    for (int i = 0; i < 8; i++) begin
      bit_io(1'b1, 1'b0, s, p);
      d = {d[6:0], s};
    end
    bit_io(~mack, 1'b0, s, p);
    chk(p == 1'b0, "R9 released in master ack", p, 0);
  endtask

  task automatic wr_burst(input logic [7:0] sub, input int n);
    logic a;
    logic [6:0] p;
    int w0;
    w0 = wr_cnt;
    bstart();
    wbyte(8'hBE, -1, a); chk(a, "R2 write address ack", a, 1);
    wbyte(sub, -1, a);   chk(a, "R4 sub-address ack", a, 1);
    p = sub[6:0];
    for (int k = 0; k < n; k++) begin
      wbyte(wbuf[k], -1, a);
      chk(a, "R5 data ack", a, 1);
      expv[p] = wbuf[k];
      if (sub[7]) p = p + 7'd1;
    end
    bstop();
    chk(wr_cnt - w0 == n, "R5 write strobe count", wr_cnt - w0, n);
  endtask

  task automatic rd_burst(input logic [7:0] sub, input int n, input string tag);
    logic a, s, pp;
    logic [7:0] d;
    logic [6:0] p;
    int r0;
    bstart();
    wbyte(8'hBE, -1, a);
    wbyte(sub, -1, a);
    r0 = rd_cnt;
    bstart();
    wbyte(8'hBF, -1, a); chk(a, "R7 read address ack", a, 1);
    p = sub[6:0];
    for (int k = 0; k < n; k++) begin
      rbyte(k != n - 1, d);
      chk(d == expv[p], tag, d, expv[p]);
      if (sub[7]) p = p + 7'd1;
    end
    bit_io(1'b1, 1'b0, s, pp); // one extra clock after the NACK
    chk(pp == 1'b0, "R8 released after NACK", pp, 0);
    bstop();
    chk(rd_cnt - r0 == n, "R8 read strobe count", rd_cnt - r0, n);
  endtask

  initial begin
    logic a;
    logic s, p;
    int w0;
    for (int i = 0; i < 128; i++) expv[i] = init_val(i);
    wt(5);
    rst = 1'b0;
    wt(2);
    // R1 reset state
    chk(sda_pull == 1'b0, "R1 sda_pull after reset", sda_pull, 0);
    chk(reg_wr_en == 1'b0, "R1 reg_wr_en after reset", reg_wr_en, 0);
    chk(reg_rd_en == 1'b0, "R1 reg_rd_en after reset", reg_rd_en, 0);
    wt(20);

    // R2 / R3 sweep of every write-form address
    for (int ad = 0; ad < 128; ad++) begin
      w0 = wr_cnt;
      bstart();
      wbyte({7'(ad), 1'b0}, -1, a);
      if (ad == 7'h5F) chk(a == 1'b1, "R2 own address acked", a, 1);
      else             chk(a == 1'b0, "R3 foreign address not acked", a, 0);
      bstop();
      chk(wr_cnt == w0, "R3 no write on address-only transfer", wr_cnt - w0, 0);
    end

    // R3 mismatch followed by data-like bytes
    w0 = wr_cnt;
    bstart();
    wbyte(8'hBC, -1, a); chk(a == 1'b0, "R3 mismatch no ack", a, 0);
    wbyte(8'h20, -1, a); chk(a == 1'b0, "R3 ignored sub byte", a, 0);
    wbyte(8'h77, -1, a); chk(a == 1'b0, "R3 ignored data byte", a, 0);
    bstop();
    chk(wr_cnt == w0, "R3 no write after mismatch", wr_cnt - w0, 0);

    // R5 / R6 sweep of auto-increment bursts
    for (int k = 0; k < 16; k++) begin
      for (int j = 0; j < 3; j++) wbuf[j] = 8'((k * 8 + 3 + j) * 37 + 5);
      wr_burst(8'h80 | 8'(k * 8 + 3), 3);
    end

    // R6 auto-increment off: all bytes land on one register
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_burst(8'h10, 3);
    // R6 pointer wraps from 127 to 0
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
    wr_burst(8'hFE, 4);

    // R10 parked: full write attempt has no effect
    bus_sel = 1'b0;
    wt(10);
    w0 = wr_cnt;
    bstart();
    wbyte(8'hBE, -1, a); chk(a == 1'b0, "R10 no ack while parked", a, 0);
    wbyte(8'h30, -1, a);
    wbyte(8'h99, -1, a); chk(a == 1'b0, "R10 no data ack while parked", a, 0);
    bstop();
    chk(wr_cnt == w0, "R10 no write while parked", wr_cnt - w0, 0);
    bus_sel = 1'b1;
    wt(10);

    // R11 stop in the middle of a data byte
    w0 = wr_cnt;
    bstart();
    wbyte(8'hBE, -1, a);
    wbyte(8'h40, -1, a);
    for (int i = 0; i < 4; i++) bit_io(1'b0, 1'b0, s, p);
    bstop();
    chk(wr_cnt == w0, "R11 partial byte dropped", wr_cnt - w0, 0);

    // R12 short SDA glitch during a high data bit
    bstart();
    wbyte(8'hBE, -1, a);
    wbyte(8'h50, -1, a);
    wbyte(8'hF3, 7, a); chk(a == 1'b1, "R12 byte acked despite glitch", a, 1);
    bstop();
    expv[7'h50] = 8'hF3;

    // R7 / R8 whole register space in one burst, then targeted reads
    rd_burst(8'h80, 128, "R7 burst readback");
    rd_burst(8'h7E, 3, "R6 read without increment");
    rd_burst(8'hFF, 2, "R6 read wraps to 0");
    rd_burst(8'h50, 1, "R12 glitched byte readback");

    chk(r9_bad == 0, "R9 drive moved while SCL high", r9_bad, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule